// File: doc/BRIEF.md
# Accelerator Port Soft-Reset Header

This block is the control and status header for a single accelerator port. It sits between a host register interface and one accelerator slot. It holds four 64-bit registers: capability, control, status and access error. Through the control register, software drives a soft reset into the accelerator. The block then reports an acknowledge once the port has quiesced. Quiesced means every request the accelerator has in flight has completed, and the reset has been held for a minimum number of cycles.

While soft reset is held, two things happen. Host MMIO traffic aimed at the accelerator is not forwarded. The accelerator may not start new requests. Each blocked host access sets a sticky error bit. A blocked read still completes on the host side, returning all ones, so the host never stalls. The block also keeps two sticky event flags, a latency-tolerance enable bit, a read-only port number and a read-only power-state field.

Register words are selected by `regAddr`:

| regAddr | Register |
|---|---|
| 0 | capability |
| 1 | control |
| 2 | status |
| 3 | access error |

Read data appears on `regRdData` with `regRdValid` one cycle after `regRdEn`. The host keeps at most one MMIO read open at a time.

Top module: `port_hdr_top`

## Requirements
- R1: After power-on reset, the soft-reset bit (control bit 0) reads 1 and `accSoftReset` is high. The latency bit (control bit 1), both event bits and the error bit read 0.
- R2: The acknowledge (control bit 2) reads 1 only while soft reset is held, the outstanding-request count is zero, and at least MIN_PULSE cycles have passed since the soft-reset bit last rose. Once set, it stays set until software clears the soft-reset bit.
- R3: Writing 0 to control bit 0 drops `accSoftReset` and the acknowledge on the next cycle, and the port resumes normal operation.
- R4: `accReqGrant` follows `accReqIssue` only when the port is out of reset and fewer than MAX_OUTS requests are open. A grant adds one to the open count and `accReqDone` removes one. The acknowledge waits until the count reaches zero.
- R5: While the port is in reset, a host MMIO access does not raise `accMmioReq`. A blocked read returns all ones with `hostRspValid` one cycle later.
- R6: Every blocked host MMIO access, read or write, sets the error bit (error register bit 0). The bit stays set until a write of 1 to that bit. Writing 0 leaves it unchanged.
- R7: A pulse on `evtA` sets status bit 0 and a pulse on `evtB` sets status bit 1. Writing 1 to a bit clears it. A pulse arriving in the same cycle as the clear wins.
- R8: Control bit 1 is the latency-tolerance enable. It is written together with the soft-reset bit and drives `ltrEn`. Writes to the acknowledge bit are ignored.
- R9: Capability bits [7:0] read the PORT_ID parameter. Writes to the capability register are ignored.
- R10: Status bits [9:8] read the `pwrState` input. Writes do not change them.
- R11: While the port is out of reset, a host MMIO access is passed straight through to `accMmioReq`, with its address, write flag and write data. An accelerator response reaches `hostRspValid`/`hostRspData` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Header register write strobe |
| regRdEn | input | 1 | Header register read strobe |
| regAddr | input | 2 | Header register word select |
| regWrData | input | 64 | Header register write data |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| regRdData | output | 64 | Header register read data |
| hostMmioReq | input | 1 | Host access to accelerator space |
| hostMmioWr | input | 1 | Host access is a write |
| hostMmioAddr | input | MMIO_AW | Host access address |
| hostMmioWrData | input | 64 | Host write data |
| hostRspValid | output | 1 | Read response to host |
| hostRspData | output | 64 | Read response data |
| accMmioReq | output | 1 | Forwarded access to the accelerator |
| accMmioWr | output | 1 | Forwarded access is a write |
| accMmioAddr | output | MMIO_AW | Forwarded address |
| accMmioWrData | output | 64 | Forwarded write data |
| accRspValid | input | 1 | Accelerator read response |
| accRspData | input | 64 | Accelerator read data |
| accReqIssue | input | 1 | Accelerator asks to issue a request |
| accReqGrant | output | 1 | Request accepted and counted |
| accReqDone | input | 1 | One open request completed |
| accSoftReset | output | 1 | Soft reset into the accelerator |
| ltrEn | output | 1 | Latency-tolerance enable |
| evtA | input | 1 | Event A set pulse |
| evtB | input | 1 | Event B set pulse |
| pwrState | input | PWR_W | Current power state |

## Verification
The bench targets the two-condition acknowledge in three ways:
- It holds requests open past the pulse width. A design that watched only the timer would acknowledge too early.
- It reads the acknowledge well inside the pulse window. A design that ignored the timer would report it there.
- It clears soft reset after an acknowledge. A stale acknowledge or a stuck reset output would show up here.

Blocked accesses are checked for three faults: a leak to the accelerator, a read that never completes, and a missing or non-sticky error bit. Two write cases are checked for being ignored: a write of 0 to the error bit, and a write to the capability word. The bench also sends an event in the same cycle as its clear. A design that gave the clear priority would lose that event.

// File: rtl/port_hdr_pkg.sv
package port_hdr_pkg;

  typedef enum logic [1:0] {
    SEL_CAP  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STS  = 2'd2,
    SEL_ERR  = 2'd3
  } regSel_e;

  // Strobes from control decode to the datapath, valid for one cycle.
  typedef struct packed {
    logic    wrCtrl;
    logic    clrSts;
    logic    clrErr;
    logic    rdEn;
    regSel_e rdSel;
    logic    blockRd;
    logic    blockAny;
  } hdrStrobe_t;

  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_LTR_BIT = 1;
  localparam int CTRL_ACK_BIT = 2;
  localparam int STS_PWR_LSB  = 8;

endpackage

// File: rtl/port_hdr_ctrl.sv
module port_hdr_ctrl
  import port_hdr_pkg::*;
#(
  parameter int MMIO_AW = 16,
  parameter int DATA_W  = 64
) (
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic               hostMmioReq,
  input  logic               hostMmioWr,
  input  logic [MMIO_AW-1:0] hostMmioAddr,
  input  logic [DATA_W-1:0]  hostMmioWrData,
  input  logic               softRst,
  output logic               accMmioReq,
  output logic               accMmioWr,
  output logic [MMIO_AW-1:0] accMmioAddr,
  output logic [DATA_W-1:0]  accMmioWrData,
  output hdrStrobe_t         strobe
);

  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  // Register-side decode.
  always_comb begin
    strobe          = '0;
    strobe.rdEn     = regRdEn;
    strobe.rdSel    = sel;
    strobe.wrCtrl   = regWrEn && (sel == SEL_CTRL);
    strobe.clrSts   = regWrEn && (sel == SEL_STS);
    strobe.clrErr   = regWrEn && (sel == SEL_ERR);
    strobe.blockAny = hostMmioReq && softRst;
    strobe.blockRd  = hostMmioReq && softRst && !hostMmioWr;
  end

  // Accelerator MMIO gate: nothing passes while the port is in reset.
  assign accMmioReq    = hostMmioReq && !softRst;
  assign accMmioWr     = hostMmioWr;
  assign accMmioAddr   = hostMmioAddr;
  assign accMmioWrData = hostMmioWrData;

endmodule

// File: rtl/port_hdr_dp.sv
module port_hdr_dp
  import port_hdr_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int PORT_ID   = 3,
  parameter int MIN_PULSE = 16,
  parameter int MAX_OUTS  = 15,
  parameter int PWR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdrStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWrData,
  output logic              regRdValid,
  output logic [DATA_W-1:0] regRdData,
  input  logic              accRspValid,
  input  logic [DATA_W-1:0] accRspData,
  output logic              hostRspValid,
  output logic [DATA_W-1:0] hostRspData,
  input  logic              accReqIssue,
  output logic              accReqGrant,
  input  logic              accReqDone,
  input  logic              evtA,
  input  logic              evtB,
  input  logic [PWR_W-1:0]  pwrState,
  output logic              softRst,
  output logic              ltrEn
);

  localparam int CNT_W = $clog2(MAX_OUTS + 1);
  localparam int TMR_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTS);
  localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(MIN_PULSE);

  logic [CNT_W-1:0] openCnt;
  logic [TMR_W-1:0] pulseTmr;
  logic [1:0]       evtBits;
  logic             errBit;
  logic             ack;
  logic             cntInc;
  logic             cntDec;
  logic             unusedWd;

  assign unusedWd = ^regWrData[DATA_W-1:3];

  // Control register fields.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst <= 1'b1;
      ltrEn   <= 1'b0;
    end else if (strobe.wrCtrl) begin
      softRst <= regWrData[CTRL_RST_BIT];
      ltrEn   <= regWrData[CTRL_LTR_BIT];
    end
  end

  // Minimum pulse timer: held at zero while out of reset, so it restarts on each rise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseTmr <= '0;
    else if (!softRst)          pulseTmr <= '0;
    else if (pulseTmr != TMR_MAX) pulseTmr <= pulseTmr + 1'b1;
  end

  // Outstanding request tracking.
  assign accReqGrant = accReqIssue && !softRst && (openCnt != CNT_MAX);
  assign cntInc      = accReqGrant;
  assign cntDec      = accReqDone && (openCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                openCnt <= '0;
    else if (cntInc && !cntDec) openCnt <= openCnt + 1'b1;
    else if (cntDec && !cntInc) openCnt <= openCnt - 1'b1;
  end

  assign ack = softRst && (pulseTmr == TMR_MAX) && (openCnt == '0);

  // Sticky events and blocked-access error; a set in the same cycle beats a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtBits <= '0;
      errBit  <= 1'b0;
    end else begin
      evtBits[0] <= evtA | (evtBits[0] & ~(strobe.clrSts & regWrData[0]));
      evtBits[1] <= evtB | (evtBits[1] & ~(strobe.clrSts & regWrData[1]));
      errBit     <= strobe.blockAny | (errBit & ~(strobe.clrErr & regWrData[0]));
    end
  end

  // Register read port.
  logic [DATA_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    case (strobe.rdSel)
      SEL_CAP:  rdMux[7:0] = 8'(PORT_ID);
      SEL_CTRL: begin
        rdMux[CTRL_RST_BIT] = softRst;
        rdMux[CTRL_LTR_BIT] = ltrEn;
        rdMux[CTRL_ACK_BIT] = ack;
      end
      SEL_STS: begin
        rdMux[1:0] = evtBits;
        rdMux[STS_PWR_LSB +: PWR_W] = pwrState;
      end
      default:  rdMux[0] = errBit;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= strobe.rdEn;
      if (strobe.rdEn) regRdData <= rdMux;
    end
  end

  // Host response: accelerator data, or all ones for a blocked read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRspValid <= 1'b0;
      hostRspData  <= '0;
    end else begin
      hostRspValid <= accRspValid | strobe.blockRd;
      hostRspData  <= strobe.blockRd ? '1 : accRspData;
    end
  end

  // Acknowledge cannot appear in the first cycle after the reset bit rises.
  p_ack_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRst) |-> !ack);

  // Once acknowledged, it holds until software rewrites the control register.
  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !strobe.wrCtrl) |=> ack);

  // The open count never grows while the port is held in reset.
  p_no_growth_r4: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (openCnt <= $past(openCnt)));

  // A blocked read completes with all ones on the next cycle.
  p_blocked_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.blockRd && !accRspValid) |=> (hostRspValid && (hostRspData == '1)));

  // The error bit is sticky unless a clear is written.
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errBit && !strobe.clrErr) |=> errBit);

  // An event pulse is always captured.
  p_evt_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtA |=> evtBits[0]);

endmodule

// File: rtl/port_hdr_top.sv
module port_hdr_top
  import port_hdr_pkg::*;
#(
  parameter int MMIO_AW   = 16,
  parameter int PORT_ID   = 3,
  parameter int MIN_PULSE = 16,
  parameter int MAX_OUTS  = 15,
  parameter int PWR_W     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [63:0]        regWrData,
  output logic               regRdValid,
  output logic [63:0]        regRdData,
  input  logic               hostMmioReq,
  input  logic               hostMmioWr,
  input  logic [MMIO_AW-1:0] hostMmioAddr,
  input  logic [63:0]        hostMmioWrData,
  output logic               hostRspValid,
  output logic [63:0]        hostRspData,
  output logic               accMmioReq,
  output logic               accMmioWr,
  output logic [MMIO_AW-1:0] accMmioAddr,
  output logic [63:0]        accMmioWrData,
  input  logic               accRspValid,
  input  logic [63:0]        accRspData,
  input  logic               accReqIssue,
  output logic               accReqGrant,
  input  logic               accReqDone,
  output logic               accSoftReset,
  output logic               ltrEn,
  input  logic               evtA,
  input  logic               evtB,
  input  logic [PWR_W-1:0]   pwrState
);

  localparam int DATA_W = 64;

  hdrStrobe_t strobe;
  logic       softRst;

  port_hdr_ctrl #(.MMIO_AW(MMIO_AW), .DATA_W(DATA_W)) uCtrl (
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn),
    .regAddr        (regAddr),
    .hostMmioReq    (hostMmioReq),
    .hostMmioWr     (hostMmioWr),
    .hostMmioAddr   (hostMmioAddr),
    .hostMmioWrData (hostMmioWrData),
    .softRst        (softRst),
    .accMmioReq     (accMmioReq),
    .accMmioWr      (accMmioWr),
    .accMmioAddr    (accMmioAddr),
    .accMmioWrData  (accMmioWrData),
    .strobe         (strobe)
  );

  port_hdr_dp #(
    .DATA_W(DATA_W), .PORT_ID(PORT_ID), .MIN_PULSE(MIN_PULSE),
    .MAX_OUTS(MAX_OUTS), .PWR_W(PWR_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .regWrData    (regWrData),
    .regRdValid   (regRdValid),
    .regRdData    (regRdData),
    .accRspValid  (accRspValid),
    .accRspData   (accRspData),
    .hostRspValid (hostRspValid),
    .hostRspData  (hostRspData),
    .accReqIssue  (accReqIssue),
    .accReqGrant  (accReqGrant),
    .accReqDone   (accReqDone),
    .evtA         (evtA),
    .evtB         (evtB),
    .pwrState     (pwrState),
    .softRst      (softRst),
    .ltrEn        (ltrEn)
  );

  assign accSoftReset = softRst;

endmodule

// File: tb/port_hdr_top_test.sv
`timescale 1ns/1ps
module port_hdr_top_test;

  localparam int MMIO_AW   = 16;
  localparam int PORT_ID   = 3;
  localparam int MIN_PULSE = 16;
  localparam int PWR_W     = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]         regAddr = '0;
  logic [63:0]        regWrData = '0;
  logic               regRdValid;
  logic [63:0]        regRdData;
  logic               hostMmioReq = 1'b0, hostMmioWr = 1'b0;
  logic [MMIO_AW-1:0] hostMmioAddr = '0;
  logic [63:0]        hostMmioWrData = '0;
  logic               hostRspValid;
  logic [63:0]        hostRspData;
  logic               accMmioReq, accMmioWr;
  logic [MMIO_AW-1:0] accMmioAddr;
  logic [63:0]        accMmioWrData;
  logic               accRspValid = 1'b0;
  logic [63:0]        accRspData = '0;
  logic               accReqIssue = 1'b0, accReqDone = 1'b0;
  logic               accReqGrant, accSoftReset, ltrEn;
  logic               evtA = 1'b0, evtB = 1'b0;
  logic [PWR_W-1:0]   pwrState = '0;

  int checks = 0;
  int bad = 0;
  logic [63:0] rd;

  always #4 clk = ~clk;

  port_hdr_top #(.MMIO_AW(MMIO_AW), .PORT_ID(PORT_ID), .MIN_PULSE(MIN_PULSE),
                 .PWR_W(PWR_W)) uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    if (!regRdValid) begin
      checks++; bad++;
      $display("FAIL regRdValid act=0 exp=1");
    end
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 accSoftReset after reset", {63'd0, accSoftReset}, 64'd1);
    regRead(2'd1, rd); check("R1 ctrl after reset", rd & 64'h3, 64'h1);
    regRead(2'd2, rd); check("R1 events after reset", rd & 64'h3, 64'h0);
    regRead(2'd3, rd); check("R1 error after reset", rd, 64'h0);
    idle(MIN_PULSE + 2);
    regRead(2'd1, rd); check("R2 ack after power-on pulse", rd, 64'h5);
  endtask

  task automatic t_enable;
    regWrite(2'd1, 64'h4);
    check("R3 accSoftReset cleared", {63'd0, accSoftReset}, 64'd0);
    regRead(2'd1, rd); check("R3 ack drops, ack write ignored R8", rd, 64'h0);
  endtask

  task automatic t_ltr;
    regWrite(2'd1, 64'h2);
    check("R8 ltrEn set", {63'd0, ltrEn}, 64'd1);
    regRead(2'd1, rd); check("R8 ctrl with ltr", rd, 64'h2);
    check("R8 port stays enabled", {63'd0, accSoftReset}, 64'd0);
    regWrite(2'd1, 64'h0);
    check("R8 ltrEn cleared", {63'd0, ltrEn}, 64'd0);
  endtask

  task automatic t_pass;
    @(negedge clk);
    hostMmioReq = 1'b1; hostMmioWr = 1'b0; hostMmioAddr = 16'h1230;
    #1;
    check("R11 read forwarded", {63'd0, accMmioReq}, 64'd1);
    check("R11 address forwarded", {48'd0, accMmioAddr}, 64'h1230);
    @(negedge clk);
    hostMmioReq = 1'b0;
    accRspValid = 1'b1; accRspData = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    accRspValid = 1'b0;
    check("R11 response valid", {63'd0, hostRspValid}, 64'd1);
    check("R11 response data", hostRspData, 64'hDEAD_BEEF_0123_4567);
    hostMmioReq = 1'b1; hostMmioWr = 1'b1; hostMmioWrData = 64'h55AA;
    #1;
    check("R11 write forwarded", {62'd0, accMmioReq, accMmioWr}, 64'h3);
    check("R11 write data", accMmioWrData, 64'h55AA);
    @(negedge clk);
    hostMmioReq = 1'b0; hostMmioWr = 1'b0;
    regRead(2'd3, rd); check("R6 no error when enabled", rd, 64'h0);
  endtask

  task automatic t_drain;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      accReqIssue = 1'b1;
      #1;
      check("R4 grant when enabled", {63'd0, accReqGrant}, 64'd1);
    end
    @(negedge clk);
    accReqIssue = 1'b0;
    regWrite(2'd1, 64'h1);
    accReqIssue = 1'b1;
    #1;
    check("R4 no grant in reset", {63'd0, accReqGrant}, 64'd0);
    idle(MIN_PULSE + 4);
    accReqIssue = 1'b0;
    regRead(2'd1, rd); check("R4 no ack with open requests", rd, 64'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      accReqDone = 1'b1;
    end
    @(negedge clk);
    accReqDone = 1'b0;
    regRead(2'd1, rd); check("R2 ack after drain", rd, 64'h5);
  endtask

  task automatic t_pulse;
    regWrite(2'd1, 64'h0);
    regWrite(2'd1, 64'h1);
    idle(3);
    regRead(2'd1, rd); check("R2 no ack inside pulse window", rd, 64'h1);
    idle(MIN_PULSE);
    regRead(2'd1, rd); check("R2 ack after pulse window", rd, 64'h5);
  endtask

  task automatic t_block;
    @(negedge clk);
    hostMmioReq = 1'b1; hostMmioWr = 1'b0; hostMmioAddr = 16'h0040;
    #1;
    check("R5 blocked read not forwarded", {63'd0, accMmioReq}, 64'd0);
    @(negedge clk);
    hostMmioReq = 1'b0;
    check("R5 blocked read completes", {63'd0, hostRspValid}, 64'd1);
    check("R5 blocked read data all ones", hostRspData, '1);
    regRead(2'd3, rd); check("R6 error set by blocked read", rd, 64'h1);
    idle(3);
    regRead(2'd3, rd); check("R6 error sticky", rd, 64'h1);
    regWrite(2'd3, 64'h0);
    regRead(2'd3, rd); check("R6 write 0 ignored", rd, 64'h1);
    regWrite(2'd3, 64'h1);
    regRead(2'd3, rd); check("R6 write 1 clears", rd, 64'h0);
    @(negedge clk);
    hostMmioReq = 1'b1; hostMmioWr = 1'b1;
    #1;
    check("R5 blocked write not forwarded", {63'd0, accMmioReq}, 64'd0);
    @(negedge clk);
    hostMmioReq = 1'b0; hostMmioWr = 1'b0;
    check("R5 blocked write gives no response", {63'd0, hostRspValid}, 64'd0);
    regRead(2'd3, rd); check("R6 error set by blocked write", rd, 64'h1);
    regWrite(2'd3, 64'h1);
  endtask

  task automatic t_ack_drop;
    regRead(2'd1, rd); check("R2 ack held", rd, 64'h5);
    regWrite(2'd1, 64'h0);
    check("R3 port enabled", {63'd0, accSoftReset}, 64'd0);
    regRead(2'd1, rd); check("R3 ack cleared", rd, 64'h0);
  endtask

  task automatic t_events;
    pwrState = 2'd2;
    @(negedge clk); evtA = 1'b1;
    @(negedge clk); evtA = 1'b0;
    regRead(2'd2, rd); check("R7 event A sticky, R10 power", rd, 64'h201);
    @(negedge clk); evtB = 1'b1;
    @(negedge clk); evtB = 1'b0;
    regRead(2'd2, rd); check("R7 both events", rd, 64'h203);
    regWrite(2'd2, 64'h301);
    regRead(2'd2, rd); check("R7 clear A, R10 power read-only", rd, 64'h202);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 64'h2; evtB = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtB = 1'b0;
    regRead(2'd2, rd); check("R7 set beats clear", rd, 64'h202);
    regWrite(2'd2, 64'h2);
    pwrState = 2'd1;
    regRead(2'd2, rd); check("R7 cleared, R10 follows input", rd, 64'h100);
  endtask

  task automatic t_cap;
    regRead(2'd0, rd); check("R9 port id", rd, 64'(PORT_ID));
    regWrite(2'd0, 64'hFF);
    regRead(2'd0, rd); check("R9 capability write ignored", rd, 64'(PORT_ID));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_enable();
    t_ltr();
    t_pass();
    t_drain();
    t_pulse();
    t_block();
    t_ack_drop();
    t_events();
    t_cap();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule